// File: doc/BRIEF.md
# DMA Transfer Request Register Front-End

This block is the software-facing register file of a single-channel DMA engine. Software programs the source and destination addresses, the row length, an optional row count and the two strides, and a small set of transfer flags. It then commits the transfer by writing the start register. Each committed transfer is stamped with a 5-bit transfer ID and placed in a small request queue. The queue feeds the data movers through a valid/ready handshake. The block allocates IDs one after another, and software can read the next ID before it commits, so it knows which tag its transfer will carry.

When the data movers finish a transfer they return its ID. The block collects finished IDs in a bitmap that clears on read, and keeps interrupt state for two events: a request leaving the queue (start-of-transfer) and a transfer finishing (end-of-transfer). A control register enables the engine, pauses issue, or discards everything queued.

Top module: `dmareq_frontend`

## Requirements
- R1: After reset, control reads 0, the interrupt mask reads 3 (both events masked), pending reads 0, the next-ID register (0x404) reads 0, the start register reads 0, the done bitmap reads 0 and `req_valid` is low.
- R2: A write to the start register (0x408) with data bit 0 set, while enabled (control bit 0), places the programmed addresses, lengths, strides and flags in the queue under the ID shown at 0x404. The next ID then advances by one and wraps from 31 to 0.
- R3: A start write while control bit 0 is clear is ignored: the next ID does not change and no request is issued.
- R4: The start register reads 1 while the queue holds DEPTH requests and 0 otherwise. A start write while the queue is full is ignored.
- R5: With control bit 0 set and bit 1 (pause) clear, the oldest queued request is presented on `req_*` with `req_valid` high. It leaves the queue on a cycle where `req_valid` and `req_ready` are both high, and requests leave in commit order.
- R6: While pause (control bit 1) is set, `req_valid` stays low and queued requests are held.
- R7: Writing the control register (0x400) with bit 0 clear discards every queued request. The next ID is kept.
- R8: Pending (0x84) bit 0 (start-of-transfer) sets when a request leaves the queue. Pending bit 1 (end-of-transfer) sets on every completion. Writing ones to pending clears those bits, and a new event in the same cycle wins over the clear.
- R9: The source register (0x88) reads pending AND NOT mask (0x80, bit set = masked), and `irq` is high exactly when some source bit is set.
- R10: A completion sets bit `cpl_id` of the done register (0x428). Bit 31 also reads 1 while a partial-report flag (`cpl_partial` with a completion) is held. Reading 0x428 returns the map and clears only the bits that were set in the returned value, so a completion arriving in the same cycle survives.
- R11: The X length (0x418) keeps LEN_W bits with its low ALIGN_BITS bits forced to one. Writing all ones reads back the maximum length 2^LEN_W-1, and writing 0 reads back the alignment mask 2^ALIGN_BITS-1.
- R12: The flags register (0x40c) keeps bits [2:0] (cyclic, last, partial-report) and reads 0 above them. The address registers keep AW bits, and Y length and strides keep LEN_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe, data returned next cycle |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt, any unmasked pending event |
| req_valid | output | 1 | Queued request presented to the datapath |
| req_ready | input | 1 | Datapath accepts the presented request |
| req_id | output | 5 | Transfer ID of the request |
| req_flags | output | 3 | Flags of the request |
| req_dst | output | AW | Destination address |
| req_src | output | AW | Source address |
| req_xlen | output | LEN_W | Row length minus one |
| req_ylen | output | LEN_W | Row count minus one |
| req_dstride | output | LEN_W | Destination stride |
| req_sstride | output | LEN_W | Source stride |
| cpl_valid | input | 1 | Completion strobe from the datapath |
| cpl_id | input | 5 | ID of the finished transfer |
| cpl_partial | input | 1 | Completion carries a partial-transfer report |

## Verification
The commit path is exercised in three states: disabled, which must leave the ID untouched; paused, which fills the queue to full and then bounces a fifth commit; and running with `req_ready` held high for 28 commits, which drives the ID through its wrap at 31. These separate the enable gate, the full gate and the counter modulus. Register readback vectors with all-ones, zero and mixed data tell the forced alignment bits apart from plain truncation. The done bitmap is read twice in a row, with a partial flag, and with a completion landing in the same cycle as the read. This separates a clear-on-read of the returned bits from a blanket clear.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
   localparam int ID_W = 5;
   localparam int FLG_W = 3;

   localparam logic [11:0] OFF_MASK   = 12'h080;
   localparam logic [11:0] OFF_PEND   = 12'h084;
   localparam logic [11:0] OFF_SRCEV  = 12'h088;
   localparam logic [11:0] OFF_CTRL   = 12'h400;
   localparam logic [11:0] OFF_NEXTID = 12'h404;
   localparam logic [11:0] OFF_START  = 12'h408;
   localparam logic [11:0] OFF_FLAGS  = 12'h40c;
   localparam logic [11:0] OFF_DST    = 12'h410;
   localparam logic [11:0] OFF_SRC    = 12'h414;
   localparam logic [11:0] OFF_XLEN   = 12'h418;
   localparam logic [11:0] OFF_YLEN   = 12'h41c;
   localparam logic [11:0] OFF_DSTR   = 12'h420;
   localparam logic [11:0] OFF_SSTR   = 12'h424;
   localparam logic [11:0] OFF_DONE   = 12'h428;

   localparam int EV_SOT = 0;
   localparam int EV_EOT = 1;

   localparam int CTL_EN    = 0;
   localparam int CTL_PAUSE = 1;
   localparam int CTL_SG    = 2;
endpackage

// File: rtl/dmareq_queue.sv
module dmareq_queue #(
   parameter int DEPTH = 4,
   parameter int DW    = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   input  logic          flush,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   AST_QUEUE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R4
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R7
endmodule

// File: rtl/dmareq_irq.sv
module dmareq_irq (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sot_evt,
   input  logic        eot_evt,
   input  logic        mask_wr,
   input  logic        pend_wr,
   input  logic [1:0]  wdata,
   output logic [1:0]  mask,
   output logic [1:0]  pending,
   output logic [1:0]  source,
   output logic        irq
);
   import dmareq_pkg::*;

   logic [1:0] clr, set;

   assign clr = pend_wr ? wdata : 2'b00;
   always_comb begin
      set = 2'b00;
      set[EV_SOT] = sot_evt;
      set[EV_EOT] = eot_evt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask    <= 2'b11;
         pending <= 2'b00;
      end else begin
         if (mask_wr) mask <= wdata;
         pending <= (pending & ~clr) | set;
      end
   end

   assign source = pending & ~mask;
   assign irq    = |source;

   AST_SOT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      sot_evt |=> pending[EV_SOT]); // R8
   AST_EOT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      eot_evt |=> pending[EV_EOT]); // R8
endmodule

// File: rtl/dmareq_done.sv
module dmareq_done (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cpl_valid,
   input  logic [4:0]  cpl_id,
   input  logic        cpl_partial,
   input  logic        rd_clear,
   output logic [31:0] done_map
);
   logic [31:0] bits_q;
   logic        part_q;
   logic [31:0] set_vec;

   assign set_vec = cpl_valid ? (32'd1 << cpl_id) : 32'd0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q <= '0;
         part_q <= 1'b0;
      end else begin
         bits_q <= (rd_clear ? 32'd0 : bits_q) | set_vec;
         part_q <= (rd_clear ? 1'b0 : part_q) | (cpl_valid && cpl_partial);
      end
   end

   assign done_map = {bits_q[31] | part_q, bits_q[30:0]};

   AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |=> done_map[$past(cpl_id)]); // R10
endmodule

// File: rtl/dmareq_frontend.sv
module dmareq_frontend #(
   parameter int DEPTH      = 4,
   parameter int AW         = 32,
   parameter int LEN_W      = 24,
   parameter int ALIGN_BITS = 2,
   parameter bit TWO_D      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [11:0]      bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output logic             irq,
   output logic             req_valid,
   input  logic             req_ready,
   output logic [4:0]       req_id,
   output logic [2:0]       req_flags,
   output logic [AW-1:0]    req_dst,
   output logic [AW-1:0]    req_src,
   output logic [LEN_W-1:0] req_xlen,
   output logic [LEN_W-1:0] req_ylen,
   output logic [LEN_W-1:0] req_dstride,
   output logic [LEN_W-1:0] req_sstride,
   input  logic             cpl_valid,
   input  logic [4:0]       cpl_id,
   input  logic             cpl_partial
);
   import dmareq_pkg::*;

   localparam int DW = ID_W + FLG_W + 2 * AW + 4 * LEN_W;
   localparam logic [LEN_W-1:0] LEN_ALIGN = LEN_W'((64'd1 << ALIGN_BITS) - 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end
   if (AW < 1 || AW > 32) begin : g_bad_aw
      $error("AW must be 1..32");
   end
   if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
      $error("LEN_W must be 1..32");
   end
   if (ALIGN_BITS >= LEN_W) begin : g_bad_align
      $error("ALIGN_BITS must be below LEN_W");
   end

   logic [2:0]       ctrl_q;
   logic [FLG_W-1:0] flags_q;
   logic [AW-1:0]    dst_q, src_q;
   logic [LEN_W-1:0] xlen_q;
   logic [LEN_W-1:0] ylen_w, dstr_w, sstr_w;
   logic [ID_W-1:0]  next_id;

   logic wr_ctrl, wr_start, commit, abort, q_full, q_empty, q_pop;
   logic [DW-1:0] q_head;
   logic [1:0]    ev_mask, ev_pend, ev_src;
   logic [31:0]   done_map;

   assign wr_ctrl  = bus_wr && (bus_addr == OFF_CTRL);
   assign wr_start = bus_wr && (bus_addr == OFF_START) && bus_wdata[0];
   assign abort    = wr_ctrl && !bus_wdata[CTL_EN];
   assign commit   = wr_start && ctrl_q[CTL_EN] && !q_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         flags_q <= '0;
         dst_q   <= '0;
         src_q   <= '0;
         xlen_q  <= LEN_ALIGN;
         next_id <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata[2:0];
         if (bus_wr && bus_addr == OFF_FLAGS) flags_q <= bus_wdata[FLG_W-1:0];
         if (bus_wr && bus_addr == OFF_DST)   dst_q <= bus_wdata[AW-1:0];
         if (bus_wr && bus_addr == OFF_SRC)   src_q <= bus_wdata[AW-1:0];
         if (bus_wr && bus_addr == OFF_XLEN)  xlen_q <= bus_wdata[LEN_W-1:0] | LEN_ALIGN;
         if (commit) next_id <= next_id + 1'b1;
      end
   end

   if (TWO_D) begin : g_two_d
      logic [LEN_W-1:0] ylen_q, dstr_q, sstr_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ylen_q <= '0;
            dstr_q <= '0;
            sstr_q <= '0;
         end else begin
            if (bus_wr && bus_addr == OFF_YLEN) ylen_q <= bus_wdata[LEN_W-1:0];
            if (bus_wr && bus_addr == OFF_DSTR) dstr_q <= bus_wdata[LEN_W-1:0];
            if (bus_wr && bus_addr == OFF_SSTR) sstr_q <= bus_wdata[LEN_W-1:0];
         end
      end
      assign ylen_w = ylen_q;
      assign dstr_w = dstr_q;
      assign sstr_w = sstr_q;
   end else begin : g_one_d
      assign ylen_w = '0;
      assign dstr_w = '0;
      assign sstr_w = '0;
   end

   dmareq_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (commit),
      .push_data ({next_id, flags_q, dst_q, src_q, xlen_q, ylen_w, dstr_w, sstr_w}),
      .pop       (q_pop),
      .flush     (abort),
      .head      (q_head),
      .empty     (q_empty),
      .full      (q_full)
   );

   assign {req_id, req_flags, req_dst, req_src,
           req_xlen, req_ylen, req_dstride, req_sstride} = q_head;
   assign req_valid = !q_empty && ctrl_q[CTL_EN] && !ctrl_q[CTL_PAUSE];
   assign q_pop     = req_valid && req_ready;

   dmareq_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .sot_evt (q_pop),
      .eot_evt (cpl_valid),
      .mask_wr (bus_wr && bus_addr == OFF_MASK),
      .pend_wr (bus_wr && bus_addr == OFF_PEND),
      .wdata   (bus_wdata[1:0]),
      .mask    (ev_mask),
      .pending (ev_pend),
      .source  (ev_src),
      .irq     (irq)
   );

   dmareq_done u_done (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpl_valid   (cpl_valid),
      .cpl_id      (cpl_id),
      .cpl_partial (cpl_partial),
      .rd_clear    (bus_rd && bus_addr == OFF_DONE),
      .done_map    (done_map)
   );

   logic [31:0] rd_mux;
   always_comb begin
      case (bus_addr)
         OFF_MASK:   rd_mux = {30'd0, ev_mask};
         OFF_PEND:   rd_mux = {30'd0, ev_pend};
         OFF_SRCEV:  rd_mux = {30'd0, ev_src};
         OFF_CTRL:   rd_mux = {29'd0, ctrl_q};
         OFF_NEXTID: rd_mux = {27'd0, next_id};
         OFF_START:  rd_mux = {31'd0, q_full};
         OFF_FLAGS:  rd_mux = 32'(flags_q);
         OFF_DST:    rd_mux = 32'(dst_q);
         OFF_SRC:    rd_mux = 32'(src_q);
         OFF_XLEN:   rd_mux = 32'(xlen_q);
         OFF_YLEN:   rd_mux = 32'(ylen_w);
         OFF_DSTR:   rd_mux = 32'(dstr_w);
         OFF_SSTR:   rd_mux = 32'(sstr_w);
         OFF_DONE:   rd_mux = done_map;
         default:    rd_mux = 32'd0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   AST_ID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> next_id == $past(next_id) + 5'd1); // R2
   AST_ID_HOLDS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start && !ctrl_q[CTL_EN]) |=> $stable(next_id)); // R3
   AST_ABORT_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !req_valid); // R7
endmodule

// File: tb/tb_dmareq_frontend.sv
`timescale 1ns/1ps
module tb_dmareq_frontend;
   localparam int AW = 32;
   localparam int LEN_W = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 0, bus_rd = 0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic irq, req_valid;
   logic req_ready = 0;
   logic [4:0] req_id;
   logic [2:0] req_flags;
   logic [AW-1:0] req_dst, req_src;
   logic [LEN_W-1:0] req_xlen, req_ylen, req_dstride, req_sstride;
   logic cpl_valid = 0, cpl_partial = 0;
   logic [4:0] cpl_id = '0;

   int n_chk = 0, n_bad = 0;
   logic [31:0] rv;

   always #10 clk = ~clk;

   dmareq_frontend dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .req_valid(req_valid), .req_ready(req_ready),
      .req_id(req_id), .req_flags(req_flags), .req_dst(req_dst),
      .req_src(req_src), .req_xlen(req_xlen), .req_ylen(req_ylen),
      .req_dstride(req_dstride), .req_sstride(req_sstride),
      .cpl_valid(cpl_valid), .cpl_id(cpl_id), .cpl_partial(cpl_partial)
   );

   // {offset, write data, expected readback}
   localparam int NV = 10;
   localparam logic [75:0] VEC [NV] = '{
      {12'h080, 32'h0000_0001, 32'h0000_0001},  // R9 mask: SOT masked only
      {12'h40c, 32'hFFFF_FFFF, 32'h0000_0007},  // R12 flags
      {12'h418, 32'hFFFF_FFFF, 32'h00FF_FFFF},  // R11 max length
      {12'h418, 32'h0000_0000, 32'h0000_0003},  // R11 alignment mask
      {12'h418, 32'h0000_1234, 32'h0000_1237},  // R11 mixed
      {12'h41c, 32'h0000_0055, 32'h0000_0055},  // R12 y length
      {12'h410, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R12 dst
      {12'h414, 32'h1234_5678, 32'h1234_5678},  // R12 src
      {12'h420, 32'h0000_0100, 32'h0000_0100},  // R12 dst stride
      {12'h424, 32'hFFFF_FFFF, 32'h00FF_FFFF}   // R12 src stride
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1; bus_addr = a;
      @(negedge clk);
      bus_rd = 0;
      d = bus_rdata;
   endtask

   task automatic complete(input logic [4:0] id, input logic part);
      @(negedge clk);
      cpl_valid = 1; cpl_id = id; cpl_partial = part;
      @(negedge clk);
      cpl_valid = 0; cpl_partial = 0;
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(12'h400, rv); chk("R1 ctrl", rv, 0);
      rd(12'h080, rv); chk("R1 mask", rv, 3);
      rd(12'h084, rv); chk("R1 pending", rv, 0);
      rd(12'h404, rv); chk("R1 next id", rv, 0);
      rd(12'h408, rv); chk("R1 start", rv, 0);
      rd(12'h428, rv); chk("R1 done", rv, 0);
      chk("R1 req_valid", {31'd0, req_valid}, 0);

      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][75:64], VEC[i][63:32]);
         rd(VEC[i][75:64], rv);
         chk($sformatf("R11/R12 vector %0d", i), rv, VEC[i][31:0]);
      end

      // R3 commit while disabled
      wr(12'h408, 1);
      rd(12'h404, rv); chk("R3 id unchanged", rv, 0);
      chk("R3 no issue", {31'd0, req_valid}, 0);

      // R6/R4 fill queue while paused
      wr(12'h400, 3);
      wr(12'h418, 32'h1230);
      wr(12'h40c, 32'h2);
      for (int k = 0; k < 4; k++) begin
         wr(12'h410, 32'h1000 * (k + 1));
         wr(12'h408, 1);
      end
      chk("R6 paused holds", {31'd0, req_valid}, 0);
      rd(12'h404, rv); chk("R2 id after 4", rv, 4);
      rd(12'h408, rv); chk("R4 full busy", rv, 1);
      wr(12'h408, 1);
      rd(12'h404, rv); chk("R4 full commit ignored", rv, 4);

      // R5 issue in order
      wr(12'h400, 1);
      chk("R5 valid", {31'd0, req_valid}, 1);
      chk("R5 head id", {27'd0, req_id}, 0);
      chk("R2 head dst", req_dst, 32'h1000);
      chk("R2 head xlen", 32'(req_xlen), 32'h1233);
      chk("R2 head flags", {29'd0, req_flags}, 2);
      @(negedge clk); req_ready = 1;
      @(negedge clk); req_ready = 0;
      chk("R5 next id", {27'd0, req_id}, 1);
      chk("R5 next dst", req_dst, 32'h2000);
      rd(12'h408, rv); chk("R4 not full", rv, 0);
      rd(12'h084, rv); chk("R8 SOT pending", rv, 1);
      chk("R9 SOT masked irq", {31'd0, irq}, 0);
      wr(12'h084, 1);
      rd(12'h084, rv); chk("R8 W1C", rv, 0);

      // R9/R10 completions
      complete(5'd0, 0);
      chk("R9 EOT irq", {31'd0, irq}, 1);
      rd(12'h088, rv); chk("R9 source", rv, 2);
      complete(5'd5, 0);
      rd(12'h428, rv); chk("R10 done map", rv, 32'h21);
      rd(12'h428, rv); chk("R10 cleared", rv, 0);
      complete(5'd2, 1);
      rd(12'h428, rv); chk("R10 partial", rv, 32'h8000_0004);
      @(negedge clk);
      bus_rd = 1; bus_addr = 12'h428; cpl_valid = 1; cpl_id = 5'd3;
      @(negedge clk);
      bus_rd = 0; cpl_valid = 0;
      chk("R10 read before set", bus_rdata, 0);
      rd(12'h428, rv); chk("R10 same-cycle survives", rv, 32'h8);

      // R7 abort
      wr(12'h400, 0);
      wr(12'h400, 1);
      chk("R7 flushed", {31'd0, req_valid}, 0);
      rd(12'h404, rv); chk("R7 id kept", rv, 4);

      // R2 wrap
      @(negedge clk); req_ready = 1;
      for (int k = 0; k < 28; k++) wr(12'h408, 1);
      @(negedge clk); req_ready = 0;
      rd(12'h404, rv); chk("R2 id wraps", rv, 0);
      chk("R5 drained", {31'd0, req_valid}, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule